// File: doc/BRIEF.md
# Channel Current-Control Register Block

This block sits on a simple word-addressed register bus and drives the current-calibration controls of a memory channel's interface cell. A configuration register holds an auto-calibration enable and a 6-bit manual current value; both fields go straight out to the cell. A separate command register has no storage of its own. Any bus write to it, whatever the data, fires a single-cycle load strobe that tells the cell to take a new value into its current-control register. With auto-calibration off, the cell takes the manual value. With it on, the cell uses a value it generates internally.

After a load with auto-calibration on, the result needs time to settle. The block raises a busy flag for a fixed number of cycles, set by a parameter. The flag drops at once if auto-calibration is switched off. A read of the command register does not return its own contents. Instead it returns a fixed mix of bits taken from neighbouring error, mode and select registers, and this block reproduces that mix. Those bits arrive as inputs. The over-range error is only recorded elsewhere and never gates the channel's packet traffic, so it has no path into this block.

Top module: `curctl_regif`

## Requirements
- R1: After reset, chan_auto_en, chan_cur, chan_load and cal_busy are all 0, and the configuration register (address 0) reads 0.
- R2: A write to address 0 stores wdata bit 6 as the auto-calibration enable and bits 5:0 as the manual current. From the cycle after the write edge, chan_auto_en equals bit 6 and chan_cur equals bits 5:0. Reading address 0 returns these 7 bits in positions 6:0, and bits above 6 read 0.
- R3: A write to address 1, with any data, drives chan_load high for exactly the one cycle after the write edge. The configuration register is left unchanged.
- R4: chan_load is never high unless an address-1 write was accepted on the edge just before. Writes to other addresses give no pulse.
- R5: A load with auto-calibration at 1 holds cal_busy high for exactly SETTLE_CYCLES cycles, starting in the cycle after the write edge.
- R6: A load with auto-calibration at 0 leaves cal_busy at 0, and cal_busy is never high while chan_auto_en is 0.
- R7: When a write clears auto-calibration during a busy period, cal_busy is 0 from the cycle after that write edge. Setting auto-calibration again does not revive the busy flag.
- R8: A load during a busy period restarts the full SETTLE_CYCLES count.
- R9: A read of address 1 returns, with no clock delay: bit 0 = err_ack_i, bits 1 and 2 = 1, bit 3 = mode_stop_i, bit 4 = sel_bit0_i, and all higher bits 0.
- R10: Addresses other than 0 and 1 read as 0, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write enable, accepted on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| err_ack_i | input | 1 | Error-acknowledge bit from the error register |
| mode_stop_i | input | 1 | Stop bit from the mode register |
| sel_bit0_i | input | 1 | Bit 0 of the timing-select register |
| chan_auto_en | output | 1 | Auto-calibration enable to the channel cell |
| chan_cur | output | 6 | Manual current value to the channel cell |
| chan_load | output | 1 | Single-cycle load strobe to the channel cell |
| cal_busy | output | 1 | Calibration settling in progress |

## Verification
Read data is combinational, so each read check is sampled in the same low clock phase in which the address is set. Register outputs (chan_auto_en, chan_cur, chan_load) are due one edge after the write edge. The bench drives every write on a falling edge and samples those outputs on the next falling edge, which is half a cycle after the edge that updates them. The busy flag is sampled on every falling edge after a load: it must read high on SETTLE_CYCLES consecutive samples and low on the next one. The early clear is checked on the first sample after the write that turns auto-calibration off.

// File: rtl/curctl_pkg.sv
package curctl_pkg;
    localparam int unsigned CUR_W     = 6;
    localparam int unsigned CFG_W     = CUR_W + 1;
    localparam int unsigned CFG_ADDR  = 0;
    localparam int unsigned LOAD_ADDR = 1;

    typedef struct packed {
        logic             auto_en;
        logic [CUR_W-1:0] cur;
    } cfg_t;
endpackage

// File: rtl/curctl_cfg_reg.sv
module curctl_cfg_reg
    import curctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cfg,
    input  logic             wr_load,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic             load
);
    typedef struct packed {
        cfg_t cfg;
        logic load;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = wr_load;
        if (wr_cfg) begin
            st_d.cfg = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg  = st_q.cfg;
    assign load = st_q.load;

    // R3 / R4: strobe only follows an accepted load write
    a_r4_load_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(wr_load));
    a_r3_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> load);
    // R2: configuration holds without a configuration write
    a_r2_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> $stable(cfg));
endmodule

// File: rtl/curctl_settle.sv
module curctl_settle #(
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!auto_en) begin
            st_d.cnt = '0;
        end else if (start) begin
            st_d.cnt = CNT_LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0) && auto_en;

    // R5: counter never exceeds the settle window
    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LOAD);
    // R8: a start while enabled reloads the full window
    a_r8_restart_full: assert property (@(posedge clk) disable iff (!rst_n)
        (start && auto_en) |=> (st_q.cnt == CNT_LOAD) || !auto_en);
endmodule

// File: rtl/curctl_rdmux.sv
module curctl_rdmux
    import curctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  cfg_t              cfg,
    input  logic              err_ack,
    input  logic              mode_stop,
    input  logic              sel_bit0,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CFG_ADDR)) begin
            rdata[CFG_W-1:0] = cfg;
        end else if (addr == ADDR_W'(LOAD_ADDR)) begin
            rdata[0] = err_ack;
            rdata[1] = 1'b1;
            rdata[2] = 1'b1;
            rdata[3] = mode_stop;
            rdata[4] = sel_bit0;
        end
    end

    // R9: stray read-back never carries bits above position 4
    always_comb begin
        if (addr == ADDR_W'(LOAD_ADDR)) begin
            a_r9_upper_zero: assert (rdata[DATA_W-1:5] == '0);
        end
    end
endmodule

// File: rtl/curctl_regif.sv
module curctl_regif
    import curctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 4,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              err_ack_i,
    input  logic              mode_stop_i,
    input  logic              sel_bit0_i,
    output logic              chan_auto_en,
    output logic [5:0]        chan_cur,
    output logic              chan_load,
    output logic              cal_busy
);
    logic wr_cfg, wr_load;
    cfg_t cfg;
    logic unused_wdata_hi;

    assign wr_cfg  = bus_we && (bus_addr == ADDR_W'(CFG_ADDR));
    assign wr_load = bus_we && (bus_addr == ADDR_W'(LOAD_ADDR));
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CFG_W];

    curctl_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cfg (wr_cfg),
        .wr_load(wr_load),
        .wdata  (bus_wdata[CFG_W-1:0]),
        .cfg    (cfg),
        .load   (chan_load)
    );

    curctl_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .auto_en(cfg.auto_en),
        .start  (wr_load),
        .busy   (cal_busy)
    );

    curctl_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .addr     (bus_addr),
        .cfg      (cfg),
        .err_ack  (err_ack_i),
        .mode_stop(mode_stop_i),
        .sel_bit0 (sel_bit0_i),
        .rdata    (bus_rdata)
    );

    assign chan_auto_en = cfg.auto_en;
    assign chan_cur     = cfg.cur;

    // R6: no settling without auto-calibration
    a_r6_busy_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> chan_auto_en);
    // R5: a load under auto-calibration starts the busy window
    a_r5_busy_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_load && chan_auto_en && $past(chan_auto_en)) |-> cal_busy);
    // R10: writes elsewhere leave the configuration and strobe alone
    a_r10_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr > ADDR_W'(LOAD_ADDR)) |=> (!chan_load && $stable(cfg)));
endmodule

// File: tb/sim_curctl_regif.sv
module sim_curctl_regif;
    localparam int unsigned SETTLE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        err_ack_i = 1'b0, mode_stop_i = 1'b0, sel_bit0_i = 1'b0;
    logic        chan_auto_en, chan_load, cal_busy;
    logic [5:0]  chan_cur;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    curctl_regif #(.SETTLE_CYCLES(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_ack_i(err_ack_i),
        .mode_stop_i(mode_stop_i), .sel_bit0_i(sel_bit0_i),
        .chan_auto_en(chan_auto_en), .chan_cur(chan_cur),
        .chan_load(chan_load), .cal_busy(cal_busy)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // called on a falling edge; returns on the next falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(chan_auto_en, 0, "R1 auto");
        chk(chan_cur, 0, "R1 cur");
        chk(chan_load, 0, "R1 load");
        chk(cal_busy, 0, "R1 busy");
        rd(4'd0, d);
        chk(d, 0, "R1 cfg read");
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        wr(4'd0, 32'h0000_0055);
        chk(chan_auto_en, 1, "R2 auto bit6");
        chk(chan_cur, 6'h15, "R2 cur bits5:0");
        chk(chan_load, 0, "R4 no strobe on cfg write");
        rd(4'd0, d);
        chk(d, 32'h55, "R2 cfg read");
        wr(4'd0, 32'hFFFF_FF2A);
        rd(4'd0, d);
        chk(d, 32'h2A, "R2 upper bits dropped");
        chk(chan_auto_en, 0, "R2 auto cleared");
    endtask

    task automatic t_load_manual();
        logic [31:0] d;
        wr(4'd1, 32'hDEAD_BEEF);
        chk(chan_load, 1, "R3 strobe cycle");
        chk(cal_busy, 0, "R6 no busy manual");
        @(negedge clk);
        chk(chan_load, 0, "R3 strobe one cycle");
        rd(4'd0, d);
        chk(d, 32'h2A, "R3 cfg untouched by load data");
        chk(chan_cur, 6'h2A, "R3 cur untouched");
    endtask

    task automatic t_busy();
        wr(4'd0, 32'h51);
        chk(cal_busy, 0, "R5 no busy before load");
        wr(4'd1, 32'h0);
        for (int i = 0; i < SETTLE; i++) begin
            chk(cal_busy, 1, "R5 busy window");
            @(negedge clk);
        end
        chk(cal_busy, 0, "R5 busy ends");
    endtask

    task automatic t_retrigger();
        wr(4'd1, 32'h1);
        repeat (3) @(negedge clk);
        chk(cal_busy, 1, "R8 busy mid window");
        wr(4'd1, 32'h2);
        for (int i = 0; i < SETTLE; i++) begin
            chk(cal_busy, 1, "R8 restarted window");
            @(negedge clk);
        end
        chk(cal_busy, 0, "R8 restarted window ends");
    endtask

    task automatic t_auto_off();
        wr(4'd1, 32'h0);
        @(negedge clk);
        chk(cal_busy, 1, "R7 busy before clear");
        wr(4'd0, 32'h11);
        chk(cal_busy, 0, "R7 busy cleared");
        chk(chan_auto_en, 0, "R7 auto off");
        wr(4'd0, 32'h51);
        chk(cal_busy, 0, "R7 busy not revived");
    endtask

    task automatic t_readmix();
        logic [31:0] d;
        for (int p = 0; p < 8; p++) begin
            err_ack_i = p[0]; mode_stop_i = p[1]; sel_bit0_i = p[2];
            rd(4'd1, d);
            chk(d, {27'b0, p[2], p[1], 2'b11, p[0]}, "R9 stray read mix");
        end
        @(negedge clk);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(4'd5, 32'hFFFF_FFFF);
        chk(chan_load, 0, "R10 no strobe");
        chk(chan_auto_en, 1, "R10 auto unchanged");
        chk(chan_cur, 6'h11, "R10 cur unchanged");
        rd(4'd5, d);
        chk(d, 0, "R10 read zero 5");
        rd(4'd15, d);
        chk(d, 0, "R10 read zero 15");
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got %0d cycles expected done", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_load_manual();
        t_busy();
        t_retrigger();
        t_auto_off();
        t_readmix();
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule